// File: doc/BRIEF.md
# Sound channel register decoder

This block turns register writes from a host bus into the stored control state of a 64-channel sample player. A write carries a window select, a byte offset inside the window and a 32-bit data word. Each window covers 32 channels, with a 128-byte register stride per channel. The decoder finds the channel and the register from the address. It extracts and merges the fields of the write into that channel's state.

The playback engine reads a channel's state combinationally by placing a channel number on the read-select input. It receives one-cycle start and stop pulses, one bit per channel, when a write to the configuration register carries a key command.

The start address is 21 bits wide and is set by two separate registers. Each of them updates only its own part. A written volume is passed through a square-law taper before it is stored, so the engine receives an already-shaped gain.

Top module: `snd_chan_regs`

## Requirements
- R1: After reset, every stored field of every channel reads back as zero, and no start or stop pulse is asserted.
- R2: The target channel is `wr_win*32 + wr_off[11:7]`, and the register selected is `wr_off[6:0]`. A write changes only the addressed channel.
- R3: A write to register 0x00 loads data bits 4:0 into start address bits 20:16 and keeps start address bits 15:0.
- R4: A write to register 0x04 loads data bits 15:0 into start address bits 15:0 and keeps start address bits 20:16.
- R5: A write to register 0x00 sets the loop flag from data bit 9. It also sets the format code from data bits 8:7 as follows: 0 gives code 0 (16-bit PCM), 1 gives code 1 (8-bit PCM), and 2 or 3 give code 2 (ADPCM).
- R6: A write to register 0x00 with data bits 15:14 equal to 3 raises `key_on[ch]`. With bits 15:14 equal to 2 it raises `key_off[ch]` instead. Either pulse is high for exactly the one cycle that follows the write edge. Codes 0 and 1 raise no pulse.
- R7: Register 0x08 stores data bits 15:0 as the loop start, register 0x0C stores data bits 15:0 as the loop end, and register 0x18 stores data bits 14:0 as the frequency word.
- R8: A write to register 0x28 stores the volume `floor(d*d/255)`, where d is data bits 7:0. This is monotonic: d from 0 to 15 gives 0, 128 gives 64, and 255 gives 255.
- R9: A write to any register offset other than 0x00, 0x04, 0x08, 0x0C, 0x18 or 0x28 changes no stored field and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 1 | Window select: 0 for channels 0-31, 1 for channels 32-63 |
| wr_off | input | 12 | Byte offset inside the window |
| wr_data | input | 32 | Write data |
| rd_chan | input | 6 | Channel whose state is presented on the rd_* outputs |
| rd_start | output | 21 | Start address |
| rd_loop | output | 1 | Loop enable |
| rd_fmt | output | 2 | Sample format code |
| rd_lstart | output | 16 | Loop start |
| rd_lend | output | 16 | Loop end |
| rd_freq | output | 15 | Frequency word |
| rd_vol | output | 8 | Tapered volume |
| key_on | output | 64 | One-cycle start pulses, one per channel |
| key_off | output | 64 | One-cycle stop pulses, one per channel |

## Verification
The assertions check several properties on every cycle. At most one start pulse and at most one stop pulse are high at a time, and no channel gets both together. Pulses appear only in the cycle after a write. Writes to undecoded offsets raise no pulse. Each half of the start address survives a write to the other half, and low volume codes always store zero.

Other behaviour can only be shown by the bench's directed scenarios. These cover the window-to-channel mapping, the decoding of the format field, the exact values of the taper at chosen points, and the fact that a channel next to the written one is left unchanged.

// File: rtl/snd_chan_regs.sv
module snd_chan_regs #(
  parameter int WIN_CH = 32,
  parameter int STRIDE_W = 7,
  parameter int ADDR_W = 21,
  parameter int LOOP_W = 16,
  parameter int FREQ_W = 15,
  parameter int VOL_W = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic                                   wr_win,
  input  logic [$clog2(WIN_CH)+STRIDE_W-1:0]     wr_off,
  input  logic [31:0]                            wr_data,
  input  logic [$clog2(2*WIN_CH)-1:0]            rd_chan,
  output logic [ADDR_W-1:0]                      rd_start,
  output logic                                   rd_loop,
  output logic [1:0]                             rd_fmt,
  output logic [LOOP_W-1:0]                      rd_lstart,
  output logic [LOOP_W-1:0]                      rd_lend,
  output logic [FREQ_W-1:0]                      rd_freq,
  output logic [VOL_W-1:0]                       rd_vol,
  output logic [2*WIN_CH-1:0]                    key_on,
  output logic [2*WIN_CH-1:0]                    key_off
);
  localparam int NCH   = 2 * WIN_CH;
  localparam int WCH_W = $clog2(WIN_CH);
  localparam int CH_W  = $clog2(NCH);
  localparam int HI_W  = ADDR_W - 16;
  localparam int VMAX  = (1 << VOL_W) - 1;

  localparam logic [STRIDE_W-1:0] R_CFG  = 'h00;
  localparam logic [STRIDE_W-1:0] R_ADLO = 'h04;
  localparam logic [STRIDE_W-1:0] R_LST  = 'h08;
  localparam logic [STRIDE_W-1:0] R_LEND = 'h0C;
  localparam logic [STRIDE_W-1:0] R_FREQ = 'h18;
  localparam logic [STRIDE_W-1:0] R_VOL  = 'h28;

  logic [ADDR_W-1:0] start_q  [NCH];
  logic              loop_q   [NCH];
  logic [1:0]        fmt_q    [NCH];
  logic [LOOP_W-1:0] lstart_q [NCH];
  logic [LOOP_W-1:0] lend_q   [NCH];
  logic [FREQ_W-1:0] freq_q   [NCH];
  logic [VOL_W-1:0]  vol_q    [NCH];

  logic [CH_W-1:0]     w_ch;
  logic [STRIDE_W-1:0] w_reg;
  logic [2*VOL_W-1:0]  vol_sq;
  logic [VOL_W-1:0]    vol_tap;
  logic [1:0]          fmt_dec;
  logic                w_hit;

  assign w_ch    = {wr_win, wr_off[WCH_W+STRIDE_W-1:STRIDE_W]};
  assign w_reg   = wr_off[STRIDE_W-1:0];
  assign vol_sq  = wr_data[VOL_W-1:0] * wr_data[VOL_W-1:0];
  assign vol_tap = VOL_W'(vol_sq / VMAX);
  assign fmt_dec = wr_data[8] ? 2'd2 : {1'b0, wr_data[7]};
  assign w_hit   = (w_reg == R_CFG) || (w_reg == R_ADLO) || (w_reg == R_LST) ||
                   (w_reg == R_LEND) || (w_reg == R_FREQ) || (w_reg == R_VOL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        start_q[i]  <= '0;
        loop_q[i]   <= 1'b0;
        fmt_q[i]    <= '0;
        lstart_q[i] <= '0;
        lend_q[i]   <= '0;
        freq_q[i]   <= '0;
        vol_q[i]    <= '0;
      end
      key_on  <= '0;
      key_off <= '0;
    end else begin
      key_on  <= '0;
      key_off <= '0;
      if (wr_en) begin
        case (w_reg)
          R_CFG: begin
            start_q[w_ch] <= {wr_data[HI_W-1:0], start_q[w_ch][15:0]};
            loop_q[w_ch]  <= wr_data[9];
            fmt_q[w_ch]   <= fmt_dec;
            if (wr_data[15:14] == 2'd3) key_on[w_ch]  <= 1'b1;
            if (wr_data[15:14] == 2'd2) key_off[w_ch] <= 1'b1;
          end
          R_ADLO: start_q[w_ch]  <= {start_q[w_ch][ADDR_W-1:16], wr_data[15:0]};
          R_LST:  lstart_q[w_ch] <= wr_data[LOOP_W-1:0];
          R_LEND: lend_q[w_ch]   <= wr_data[LOOP_W-1:0];
          R_FREQ: freq_q[w_ch]   <= wr_data[FREQ_W-1:0];
          R_VOL:  vol_q[w_ch]    <= vol_tap;
          default: ;
        endcase
      end
    end
  end

  assign rd_start  = start_q[rd_chan];
  assign rd_loop   = loop_q[rd_chan];
  assign rd_fmt    = fmt_q[rd_chan];
  assign rd_lstart = lstart_q[rd_chan];
  assign rd_lend   = lend_q[rd_chan];
  assign rd_freq   = freq_q[rd_chan];
  assign rd_vol    = vol_q[rd_chan];

  p_key_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_on) && $onehot0(key_off) && ((key_on & key_off) == '0));

  p_key_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_on | key_off) != '0) |-> $past(wr_en) && ($past(w_reg) == R_CFG));

  p_undecoded_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !w_hit) |=> (key_on == '0) && (key_off == '0));

  p_cfg_keeps_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_reg == R_CFG) |=>
      start_q[$past(w_ch)][15:0] == $past(start_q[w_ch][15:0]));

  p_adlo_keeps_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_reg == R_ADLO) |=>
      start_q[$past(w_ch)][ADDR_W-1:16] == $past(start_q[w_ch][ADDR_W-1:16]));

  p_vol_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && w_reg == R_VOL && wr_data[VOL_W-1:0] < 16) |=> vol_q[$past(w_ch)] == '0);
endmodule

// File: tb/snd_chan_regs_bench.sv
module snd_chan_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_win = 1'b0;
  logic [11:0] wr_off = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_chan = '0;
  logic [20:0] rd_start;
  logic        rd_loop;
  logic [1:0]  rd_fmt;
  logic [15:0] rd_lstart, rd_lend;
  logic [14:0] rd_freq;
  logic [7:0]  rd_vol;
  logic [63:0] key_on, key_off;
  logic [63:0] seen_on, seen_off;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  snd_chan_regs u_snd_chan_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_off(wr_off),
    .wr_data(wr_data), .rd_chan(rd_chan), .rd_start(rd_start), .rd_loop(rd_loop),
    .rd_fmt(rd_fmt), .rd_lstart(rd_lstart), .rd_lend(rd_lend), .rd_freq(rd_freq),
    .rd_vol(rd_vol), .key_on(key_on), .key_off(key_off));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(bit win, int ch, logic [6:0] rg, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = win; wr_off = {ch[4:0], rg}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    seen_on = key_on; seen_off = key_off;
  endtask

  task automatic look(int ch);
    rd_chan = ch[5:0];
    #0.1;
  endtask

  task automatic t_reset;
    for (int c = 0; c < 64; c += 21) begin
      look(c);
      check("R1 start", rd_start, 0);
      check("R1 fmt/loop", {rd_fmt, rd_loop}, 0);
      check("R1 loop pts", {rd_lstart, rd_lend}, 0);
      check("R1 freq/vol", {rd_freq, rd_vol}, 0);
    end
    check("R1 pulses", key_on | key_off, 0);
  endtask

  task automatic t_start_merge;
    wr(0, 5, 7'h04, 32'hABCD_1234);
    look(5); check("R4 low load", rd_start, 21'h0_1234);
    wr(0, 5, 7'h00, 32'h0000_0015);
    look(5); check("R3 high keeps low", rd_start, 21'h15_1234);
    wr(0, 5, 7'h04, 32'h0000_5678);
    look(5); check("R4 low keeps high", rd_start, 21'h15_5678);
    wr(0, 5, 7'h00, 32'hFFFF_FFE3);
    look(5); check("R3 replace high", rd_start, 21'h03_5678);
  endtask

  task automatic t_format;
    wr(0, 7, 7'h00, 32'h0000_0000); look(7); check("R5 code0", {rd_loop, rd_fmt}, 3'b000);
    wr(0, 7, 7'h00, 32'h0000_0080); look(7); check("R5 code1", {rd_loop, rd_fmt}, 3'b001);
    wr(0, 7, 7'h00, 32'h0000_0300); look(7); check("R5 code2+loop", {rd_loop, rd_fmt}, 3'b110);
    wr(0, 7, 7'h00, 32'h0000_0180); look(7); check("R5 code3->2", {rd_loop, rd_fmt}, 3'b010);
  endtask

  task automatic t_keys;
    wr(1, 9, 7'h00, 32'h0000_C000);
    check("R6 key on ch41", seen_on, 64'd1 << 41);
    check("R6 no off", seen_off, 0);
    @(negedge clk); check("R6 one cycle", key_on | key_off, 0);
    wr(0, 2, 7'h00, 32'h0000_8000);
    check("R6 key off ch2", seen_off, 64'd1 << 2);
    check("R6 no on", seen_on, 0);
    wr(0, 2, 7'h00, 32'h0000_4000);
    check("R6 code1 silent", seen_on | seen_off, 0);
    wr(0, 2, 7'h00, 32'h0000_0000);
    check("R6 code0 silent", seen_on | seen_off, 0);
  endtask

  task automatic t_points;
    wr(1, 3, 7'h18, 32'h7FFF_ABCD);
    look(35); check("R7 R2 freq win1", rd_freq, 15'h2BCD);
    look(3);  check("R2 win0 untouched", rd_freq, 0);
    look(34); check("R2 neighbour untouched", rd_freq, 0);
    wr(1, 31, 7'h08, 32'h1234_BEEF);
    wr(1, 31, 7'h0C, 32'h0000_C0DE);
    look(63); check("R7 loop start", rd_lstart, 16'hBEEF);
    check("R7 loop end", rd_lend, 16'hC0DE);
  endtask

  task automatic t_volume;
    int pts[6] = '{0, 15, 16, 128, 200, 255};
    for (int i = 0; i < 6; i++) begin
      wr(0, 11, 7'h28, 32'hFFFF_FF00 | pts[i]);
      look(11); check("R8 taper", rd_vol, (pts[i] * pts[i]) / 255);
    end
  endtask

  task automatic t_undecoded;
    logic [6:0] bad[4] = '{7'h10, 7'h14, 7'h24, 7'h01};
    for (int i = 0; i < 4; i++) begin
      wr(0, 5, bad[i], 32'hFFFF_FFFF);
      check("R9 no pulse", seen_on | seen_off, 0);
      look(5);
      check("R9 start kept", rd_start, 21'h03_5678);
      check("R9 others kept", {rd_lstart, rd_lend, rd_freq, rd_vol}, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start_merge();
    t_format();
    t_keys();
    t_points();
    t_volume();
    t_undecoded();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule